// File: doc/BRIEF.md
# Banked Scratchpad Conflict Serializer

This block sits in front of a word-addressed scratchpad that is split into 16 single-ported banks. A request carries up to 16 lane accesses. Each lane has a valid flag, a word address, a write enable and 32-bit write data. The block latches the whole request. It then works through it in rounds, and in each round every bank performs at most one access.

Lanes that target the same word are grouped and served together. A read to that word is broadcast to all the lanes that ask for it. Lanes that target different words in one bank are spread over successive rounds. The cost of a request is therefore set by the most heavily loaded bank. Read data is returned per lane. A one-cycle completion strobe marks the end of the request, and a round counter reports how many cycles the request used.

The banks are plain word arrays inside the block. A new request is taken only while the block is idle, which is signalled by a ready output. The first cycle in which ready is high is the cycle of the completion strobe.

Top module: `sp_bank_serializer`

## Requirements
- R1: After reset, req_ready is 1, done is 0, round_count is 0 and every lane_rdata word is 0.
- R2: A word address selects its bank by its low 4 bits (address modulo 16) and its row by the bits above. A word written through any lane is read back unchanged through any lane.
- R3: A request whose active lanes all hit different banks completes in one round. done is high in the second cycle after the accepting clock edge, and round_count reads 1.
- R4: When every active lane reads the same address, the word is broadcast to all of them in one round.
- R5: round_count equals the largest number of distinct words addressed in any one bank. Word strides of 2, 4, 8 and 16 cost 2, 4, 8 and 16 rounds. Lanes to one word are served in the same round as each other. done comes round_count cycles after acceptance.
- R6: A read returns the value the word held before the request, even when another lane of the same request writes that word.
- R7: When several lanes write one word in a request, the value of the highest-numbered writing lane is stored.
- R8: Lanes whose valid flag is 0 do not write, do not count toward round_count, and keep their previous lane_rdata value.
- R9: req_valid is taken only while req_ready is 1. req_ready stays 0 from acceptance until done. A req_valid raised while busy has no effect. done is a one-cycle pulse.
- R10: A request with no active lane completes after one cycle with round_count 0.
- R11: round_count and lane_rdata hold their values while the block is idle, until the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Offers a new request |
| req_ready | output | 1 | High while idle; a request is taken on a clock edge where both are high |
| lane_valid | input | 16 | Per-lane active flag |
| lane_addr | input | 128 | Per-lane 8-bit word address, lane i in bits [8i+7:8i] |
| lane_we | input | 16 | Per-lane write enable |
| lane_wdata | input | 512 | Per-lane write word, lane i in bits [32i+31:32i] |
| done | output | 1 | One-cycle completion strobe |
| lane_rdata | output | 512 | Per-lane read word, lane i in bits [32i+31:32i] |
| round_count | output | 5 | Rounds used by the last completed request |

## Verification
The main function is driven by a table of strided read patterns. The strides are 1, 3 and 17, which spread the lanes over all banks. A stride of 0 gives a broadcast. Strides of 2, 4, 8 and 16 stack the lanes into fewer banks. A stride of 32 makes pairs of lanes share words in one bank, which tells a count of distinct words apart from a count of lanes. A mixed pattern combines a broadcast group with conflicting words in the same bank. Directed cases cover read-before-write within a request, several writers to one word, inactive lanes, requests offered while busy, empty requests and holding results while idle.

// File: rtl/sp_pkg.sv
package sp_pkg;
    localparam int SP_LANES = 16;
    localparam int SP_BANKS = 16;
    localparam int SP_DEPTH = 16;
    localparam int SP_DW    = 32;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } sp_state_e;
endpackage

// File: rtl/sp_bank_ram.sv
module sp_bank_ram #(
    parameter int RW = 4,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [RW-1:0] row,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data
);
    localparam int DEPTH = 1 << RW;

    logic [DW-1:0] mem [DEPTH];

    // Asynchronous read gives the value before this cycle's write.
    assign rd_data = mem[row];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[row] <= wr_data;
        end
    end
endmodule

// File: rtl/sp_bank_pick.sv
module sp_bank_pick #(
    parameter int LANES   = 16,
    parameter int BW      = 4,
    parameter int RW      = 4,
    parameter int DW      = 32,
    parameter int BANK_ID = 0
) (
    input  logic [LANES-1:0]    pend,
    input  logic [LANES*BW-1:0] lane_bank,
    input  logic [LANES*RW-1:0] lane_row,
    input  logic [LANES-1:0]    lane_we,
    input  logic [LANES*DW-1:0] lane_wdata,
    output logic [LANES-1:0]    grant,
    output logic                wr_en,
    output logic [RW-1:0]       row,
    output logic [DW-1:0]       wr_data
);
    localparam logic [BW-1:0] MY_BANK = BW'(BANK_ID);

    logic [LANES-1:0] hit;
    logic             found;

    always_comb begin
        hit = '0;
        for (int i = 0; i < LANES; i++) begin
            hit[i] = pend[i] && (lane_bank[i*BW +: BW] == MY_BANK);
        end

        // Lowest pending lane in this bank chooses the row served this round.
        found = 1'b0;
        row   = '0;
        for (int i = 0; i < LANES; i++) begin
            if (hit[i] && !found) begin
                found = 1'b1;
                row   = lane_row[i*RW +: RW];
            end
        end

        // Every pending lane on that same row rides along; last writer wins.
        grant   = '0;
        wr_en   = 1'b0;
        wr_data = '0;
        for (int i = 0; i < LANES; i++) begin
            if (hit[i] && (lane_row[i*RW +: RW] == row)) begin
                grant[i] = 1'b1;
                if (lane_we[i]) begin
                    wr_en   = 1'b1;
                    wr_data = lane_wdata[i*DW +: DW];
                end
            end
        end
    end
endmodule

// File: rtl/sp_bank_serializer.sv
module sp_bank_serializer
    import sp_pkg::*;
#(
    parameter int LANES = SP_LANES,
    parameter int BANKS = SP_BANKS,
    parameter int DEPTH = SP_DEPTH,
    parameter int DW    = SP_DW,
    parameter int AW    = $clog2(BANKS * DEPTH),
    parameter int CW    = $clog2(LANES + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [LANES-1:0]    lane_valid,
    input  logic [LANES*AW-1:0] lane_addr,
    input  logic [LANES-1:0]    lane_we,
    input  logic [LANES*DW-1:0] lane_wdata,
    output logic                done,
    output logic [LANES*DW-1:0] lane_rdata,
    output logic [CW-1:0]       round_count
);
    localparam int BW = $clog2(BANKS);
    localparam int RW = AW - BW;

    typedef struct packed {
        sp_state_e             st;
        logic [LANES-1:0]      pend;
        logic [LANES*AW-1:0]   addr;
        logic [LANES-1:0]      we;
        logic [LANES*DW-1:0]   wdata;
        logic [LANES*DW-1:0]   rdata;
        logic [CW-1:0]         cnt;
        logic                  done;
    } sp_state_t;

    sp_state_t st_d, st_q;

    logic [LANES*BW-1:0] lane_bank;
    logic [LANES*RW-1:0] lane_row;
    logic [LANES-1:0]    live;
    logic [LANES-1:0]    bank_grant [BANKS];
    logic                bank_wen   [BANKS];
    logic [RW-1:0]       bank_row   [BANKS];
    logic [DW-1:0]       bank_wdata [BANKS];
    logic [DW-1:0]       bank_rdata [BANKS];
    logic [LANES-1:0]    served;

    assign live = (st_q.st == ST_RUN) ? st_q.pend : '0;

    for (genvar l = 0; l < LANES; l++) begin : g_split
        assign lane_bank[l*BW +: BW] = st_q.addr[l*AW +: BW];
        assign lane_row[l*RW +: RW]  = st_q.addr[l*AW + BW +: RW];
    end

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        sp_bank_pick #(
            .LANES(LANES), .BW(BW), .RW(RW), .DW(DW), .BANK_ID(b)
        ) u_pick (
            .pend      (live),
            .lane_bank (lane_bank),
            .lane_row  (lane_row),
            .lane_we   (st_q.we),
            .lane_wdata(st_q.wdata),
            .grant     (bank_grant[b]),
            .wr_en     (bank_wen[b]),
            .row       (bank_row[b]),
            .wr_data   (bank_wdata[b])
        );

        sp_bank_ram #(.RW(RW), .DW(DW)) u_ram (
            .clk    (clk),
            .wr_en  (bank_wen[b]),
            .row    (bank_row[b]),
            .wr_data(bank_wdata[b]),
            .rd_data(bank_rdata[b])
        );
    end

    always_comb begin
        served = '0;
        for (int b = 0; b < BANKS; b++) begin
            served = served | bank_grant[b];
        end
    end

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        case (st_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    st_d.st    = ST_RUN;
                    st_d.pend  = lane_valid;
                    st_d.addr  = lane_addr;
                    st_d.we    = lane_we;
                    st_d.wdata = lane_wdata;
                    st_d.cnt   = '0;
                end
            end
            default: begin
                st_d.pend = st_q.pend & ~served;
                if (|served) begin
                    st_d.cnt = st_q.cnt + CW'(1);
                end
                for (int i = 0; i < LANES; i++) begin
                    if (served[i]) begin
                        st_d.rdata[i*DW +: DW] = bank_rdata[lane_bank[i*BW +: BW]];
                    end
                end
                if (st_d.pend == '0) begin
                    st_d.st   = ST_IDLE;
                    st_d.done = 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_ready   = (st_q.st == ST_IDLE);
    assign done        = st_q.done;
    assign lane_rdata  = st_q.rdata;
    assign round_count = st_q.cnt;
endmodule

// File: rtl/sp_bank_serializer_chk.sv
module sp_bank_serializer_chk #(
    parameter int LANES = 16,
    parameter int DW    = 32,
    parameter int CW    = 5
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic                req_ready,
    input logic                done,
    input logic [CW-1:0]       round_count,
    input logic [LANES*DW-1:0] lane_rdata
);
    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R9
    ready_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_ready) |-> done);

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && $past(req_ready) && !$past(req_valid))
            |-> ($stable(round_count) && $stable(lane_rdata)));

    // R5
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (round_count <= CW'(LANES)));
endmodule

bind sp_bank_serializer sp_bank_serializer_chk #(
    .LANES(LANES), .DW(DW), .CW(CW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .done       (done),
    .round_count(round_count),
    .lane_rdata (lane_rdata)
);

// File: tb/sp_bank_serializer_tb.sv
`timescale 1ns/1ps
module sp_bank_serializer_tb;
    localparam int L  = 16;
    localparam int AW = 8;
    localparam int DW = 32;
    localparam int CW = 5;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic            req_ready;
    logic [L-1:0]    lv = '0;
    logic [L*AW-1:0] la = '0;
    logic [L-1:0]    lwe = '0;
    logic [L*DW-1:0] lwd = '0;
    logic            done;
    logic [L*DW-1:0] lrd;
    logic [CW-1:0]   rc;

    int total = 0;
    int bad   = 0;
    int lat;

    always #2.5 clk = ~clk;

    sp_bank_serializer u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .lane_valid(lv), .lane_addr(la), .lane_we(lwe), .lane_wdata(lwd),
        .done(done), .lane_rdata(lrd), .round_count(rc)
    );

    // {stride, base, expected rounds}
    localparam logic [20:0] VEC [10] = '{
        {8'd1,  8'd0,  5'd1},   // R3
        {8'd3,  8'd5,  5'd1},   // R3
        {8'd17, 8'd0,  5'd1},   // R3
        {8'd0,  8'd77, 5'd1},   // R4
        {8'd2,  8'd0,  5'd2},   // R5
        {8'd2,  8'd1,  5'd2},   // R5
        {8'd4,  8'd1,  5'd4},   // R5
        {8'd8,  8'd0,  5'd8},   // R5
        {8'd16, 8'd3,  5'd16},  // R5
        {8'd32, 8'd0,  5'd8}    // R5
    };

    function automatic logic [31:0] fill(input logic [7:0] a);
        return {24'hC0DE5A, a};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic do_req(output int cycles);
        @(negedge clk);
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        cycles = 1;
        while (!done && cycles < 100) begin
            @(negedge clk);
            cycles++;
        end
        cycles = cycles - 1;
    endtask

    task automatic read_one(input logic [7:0] a, output logic [31:0] d);
        int c;
        lv = 16'h0001; lwe = '0; la = '0; la[7:0] = a;
        do_req(c);
        d = lrd[31:0];
    endtask

    initial begin
        logic [31:0] d, keep;
        int miss;
        logic [7:0] a;

        #1_000_000;
        if (0) d = '0;
    end

    initial begin
        #1_000_000;
        total++;
        bad++;
        $display("FAIL watchdog act=%h exp=%h", 32'h0, 32'h1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [31:0] keep;
        int miss;
        logic [7:0] a;
        int exp_r;

        repeat (3) @(negedge clk);
        // R1 reset state
        chk(req_ready == 1'b1, "R1 ready", 32'(req_ready), 32'h1);
        chk(done == 1'b0, "R1 done", 32'(done), 32'h0);
        chk(rc == '0, "R1 count", 32'(rc), 32'h0);
        chk(lrd == '0, "R1 rdata", lrd[31:0], 32'h0);
        rst_n = 1'b1;

        // R2 fill all words through all lanes, one row per request
        for (int r = 0; r < 16; r++) begin
            lv = '1; lwe = '1;
            for (int i = 0; i < L; i++) begin
                a = 8'(r * 16 + i);
                la[i*AW +: AW] = a;
                lwd[i*DW +: DW] = fill(a);
            end
            do_req(lat);
            chk(rc == 5'd1, "R3 fill row count", 32'(rc), 32'h1);
        end

        // Strided read table: R2 data, R3/R4/R5 rounds and latency
        for (int v = 0; v < 10; v++) begin
            lv = '1; lwe = '0; lwd = '0;
            for (int i = 0; i < L; i++) begin
                la[i*AW +: AW] = 8'(VEC[v][12:5] + VEC[v][20:13] * 8'(i));
            end
            do_req(lat);
            exp_r = int'(VEC[v][4:0]);
            chk(rc == VEC[v][4:0], "R5 table round_count", 32'(rc), 32'(exp_r));
            chk(lat == exp_r, "R5 table latency", 32'(lat), 32'(exp_r));
            miss = 0;
            for (int i = 0; i < L; i++) begin
                if (lrd[i*DW +: DW] != fill(la[i*AW +: AW])) miss++;
            end
            chk(miss == 0, "R2 R4 table read data", 32'(miss), 32'h0);
        end

        // R5 broadcast group plus conflicting words in bank 10 -> 9 rounds
        lv = '1; lwe = '0;
        for (int i = 0; i < L; i++) begin
            la[i*AW +: AW] = (i < 8) ? 8'd10 : 8'(16 * (i - 8) + 26);
        end
        do_req(lat);
        chk(rc == 5'd9, "R5 mixed round_count", 32'(rc), 32'd9);
        miss = 0;
        for (int i = 0; i < L; i++) begin
            if (lrd[i*DW +: DW] != fill(la[i*AW +: AW])) miss++;
        end
        chk(miss == 0, "R4 mixed read data", 32'(miss), 32'h0);

        // R6 read-before-write within one request
        lv = 16'h0003; lwe = 16'h0002; la = '0; lwd = '0;
        la[0*AW +: AW] = 8'd7; la[1*AW +: AW] = 8'd7;
        lwd[1*DW +: DW] = 32'hBEEF_0007;
        do_req(lat);
        chk(rc == 5'd1, "R6 same word one round", 32'(rc), 32'h1);
        chk(lrd[31:0] == fill(8'd7), "R6 old value", lrd[31:0], fill(8'd7));
        read_one(8'd7, d);
        chk(d == 32'hBEEF_0007, "R6 write landed", d, 32'hBEEF_0007);

        // R7 several writers to one word: highest lane wins
        lv = 16'h1208; lwe = 16'h1208; la = '0; lwd = '0;
        la[3*AW +: AW] = 8'd5; la[9*AW +: AW] = 8'd5; la[12*AW +: AW] = 8'd5;
        lwd[3*DW +: DW] = 32'h1110_0003;
        lwd[9*DW +: DW] = 32'h1110_0009;
        lwd[12*DW +: DW] = 32'h1110_0012;
        do_req(lat);
        chk(rc == 5'd1, "R7 writers one round", 32'(rc), 32'h1);
        read_one(8'd5, d);
        chk(d == 32'h1110_0012, "R7 highest lane kept", d, 32'h1110_0012);

        // R8 inactive lanes: no write, no count, rdata kept
        keep = lrd[5*DW +: DW];
        lv = 16'h0004; lwe = '1;
        for (int i = 0; i < L; i++) begin
            la[i*AW +: AW] = 8'd9;
            lwd[i*DW +: DW] = 32'hDEAD_0000 | 32'(i);
        end
        la[2*AW +: AW] = 8'd40;
        do_req(lat);
        chk(rc == 5'd1, "R8 count only active", 32'(rc), 32'h1);
        chk(lrd[5*DW +: DW] == keep, "R8 inactive rdata kept", lrd[5*DW +: DW], keep);
        read_one(8'd9, d);
        chk(d == fill(8'd9), "R8 no write from inactive", d, fill(8'd9));
        read_one(8'd40, d);
        chk(d == 32'hDEAD_0002, "R8 active write", d, 32'hDEAD_0002);

        // R9 request offered while busy is ignored
        lv = '1; lwe = '0;
        for (int i = 0; i < L; i++) la[i*AW +: AW] = 8'(3 + 16 * i);
        @(negedge clk);
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b0, "R9 busy not ready", 32'(req_ready), 32'h0);
        lv = 16'h0001; lwe = 16'h0001; la = '0; la[7:0] = 8'd200;
        lwd = '0; lwd[31:0] = 32'hBAD0_BAD0;
        req_valid = 1'b1;
        repeat (3) @(negedge clk);
        req_valid = 1'b0;
        lat = 0;
        while (!done && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        chk(done == 1'b1 && rc == 5'd16, "R9 busy request finished", 32'(rc), 32'd16);
        @(negedge clk);
        chk(done == 1'b0, "R9 done one cycle", 32'(done), 32'h0);
        read_one(8'd200, d);
        chk(d == fill(8'd200), "R9 busy write ignored", d, fill(8'd200));

        // R10 empty request
        lv = '0; lwe = '1;
        do_req(lat);
        chk(rc == 5'd0, "R10 empty count", 32'(rc), 32'h0);
        chk(lat == 1, "R10 empty latency", 32'(lat), 32'h1);

        // R11 results hold while idle
        lv = '1; lwe = '0;
        for (int i = 0; i < L; i++) la[i*AW +: AW] = 8'(8 * i);
        do_req(lat);
        keep = lrd[15*DW +: DW];
        repeat (5) @(negedge clk);
        chk(rc == 5'd8, "R11 count held", 32'(rc), 32'd8);
        chk(lrd[15*DW +: DW] == fill(8'd120), "R11 rdata held", lrd[15*DW +: DW], fill(8'd120));

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule